// File: doc/BRIEF.md
# Frequency Lock Detector with Clock Fallback

This block watches a receive clock-recovery loop and decides whether the recovered clock can be trusted. It counts rising edges of the recovered clock over a measurement window of a fixed number of local reference clock cycles. It also watches a signal-present input from the line front end. When the count falls outside a ±0.5 % band around the nominal value, or no line signal is present, the block sits in training mode. In training mode it raises a loss-of-lock flag and drives the receive clock output from the reference clock. When the signal is present and the count has been in band for enough consecutive windows, it moves to data recovery mode. In that mode it drops the flag and hands the receive clock output over to the recovered clock.

The recovered-clock count crosses into the reference domain as a Gray-coded value through a two-flop synchronizer. The per-window count is the difference between two snapshots taken one window apart. The output clock comes from a glitch-free multiplexer. Each source is enabled only after the other has been disabled, and each enable changes while its own clock is low.

Top module: `freq_lock_detector`

## Requirements
- R1: On a synchronous active-low reset the block enters training mode. `lol_o` and `lol_status_o` read 1 and `use_rec_o` reads 0 on the first sampling point after reset is released.
- R2: When `sig_present` is 0, the block is in training mode (`lol_o` = 1) no later than three reference-clock rising edges after the input falls. It stays there while the input is low.
- R3: A measurement window whose recovered-edge count lies outside the tolerance band returns the block to training mode at the end of that window, even if it was locked.
- R4: Leaving training mode requires LOCK_WINDOWS (default 2) consecutive in-band windows that end while the signal is present. A loss of signal clears the run.
- R5: A window lasts 2^WIN_LOG2 reference cycles. A count is in band when it is between NOM_COUNT − T and NOM_COUNT + T inclusive, with T = floor(NOM_COUNT·TOL_PER_MILLE/1000). The defaults give a band of 1019..1029 on a 1024-cycle window.
- R6: In training mode, `rx_clk_o` toggles with the period of `ref_clk`.
- R7: In data recovery mode, `rx_clk_o` toggles with the period of `rec_clk`.
- R8: Switching between the two clocks produces no high or low pulse on `rx_clk_o` shorter than the shorter half period of the two clocks. The two source enables are never on together.
- R9: `lol_status_o` always equals `lol_o`, and `use_rec_o` is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; the measurement domain |
| rst_n | input | 1 | Synchronous active-low reset, reference domain |
| rec_clk | input | 1 | Recovered clock from the clock-recovery loop |
| sig_present | input | 1 | Line signal detected (asynchronous) |
| lol_o | output | 1 | Loss-of-lock flag, 1 in training mode |
| lol_status_o | output | 1 | Host-readable copy of the loss-of-lock state |
| use_rec_o | output | 1 | Clock multiplexer select, 1 = recovered clock |
| rx_clk_o | output | 1 | Receive clock output, glitch-free selected clock |

## Verification
The bench sweeps the recovered-clock period across and beyond the tolerance band. It predicts the lock decision from the window length and the period, and it skips any period whose ±1 quantization straddles a band edge. A design with an off-by-one bound, or with an exclusive instead of an inclusive compare, fails on the points just inside the band. A design that locks after a single window is caught by the check made 0.9 windows after the signal returns. A multiplexer without a handshake or without negative-edge enables produces a pulse shorter than a half period, and the pulse-width monitor flags it during the many mode switches.

// File: rtl/fld_pkg.sv
// Package: shared mode type and Gray conversion for the lock detector.
// Assumes: Gray values are standard reflected binary.
package fld_pkg;

    typedef enum logic {
        MODE_TRAIN = 1'b0,
        MODE_TRACK = 1'b1
    } mode_t;

    // Convert a reflected-binary Gray word of up to 32 bits to binary.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g, input int w);
        logic [31:0] b;
        b = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i < w) begin
                if (i == w - 1) b[i] = g[i];
                else            b[i] = b[i + 1] ^ g[i];
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/fld_sync2.sv
// Two-flop synchronizer for level or Gray-coded buses.
// Assumes: multi-bit inputs change by at most one bit per source edge.
module fld_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fld_gray_cnt.sv
// Recovered-domain edge counter with a registered Gray output.
// It also synchronizes the reference-domain reset into the recovered domain.
// Assumes: rec_clk keeps toggling while reset is asserted.
module fld_gray_cnt #(
    parameter int W = 13
) (
    input  logic         rec_clk,
    input  logic         rst_n,
    output logic [W-1:0] gray_o,
    output logic         rst_rec_n_o
);
    logic [1:0]   rst_pipe;
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nxt;

    assign bin_nxt     = bin_q + W'(1);
    assign rst_rec_n_o = rst_pipe[1];

    // Bring the reset into the recovered domain.
    always_ff @(posedge rec_clk) begin
        if (!rst_n) rst_pipe <= 2'b00;
        else        rst_pipe <= {rst_pipe[0], 1'b1};
    end

    // Count edges and publish the Gray form from a register.
    always_ff @(posedge rec_clk) begin
        if (!rst_pipe[1]) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/fld_window.sv
// Reference-domain window timer and in-band comparator.
// It snapshots the synchronized count every 2^WIN_LOG2 cycles and compares
// the difference with [LO, HI].
// Assumes: fewer than 2^CNT_W recovered edges occur per window.
module fld_window #(
    parameter int WIN_LOG2 = 10,
    parameter int CNT_W    = 13,
    parameter int LO       = 1019,
    parameter int HI       = 1029
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_s,
    output logic             win_done_o,
    output logic             win_ok_o
);
    import fld_pkg::*;

    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);

    logic [WIN_LOG2-1:0] tick_q;
    logic                at_end;
    logic                primed_q;
    logic [CNT_W-1:0]    snap_q;
    logic [CNT_W-1:0]    cur_bin;
    logic [CNT_W-1:0]    delta;
    logic [31:0]         conv;

    assign at_end  = &tick_q;
    assign conv    = gray_to_bin(32'(gray_s), CNT_W);
    assign cur_bin = conv[CNT_W-1:0];
    assign delta   = cur_bin - snap_q;

    // Free-running window timer.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + WIN_LOG2'(1);
    end

    // Snapshot at each window end and grade the elapsed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q     <= '0;
            primed_q   <= 1'b0;
            win_done_o <= 1'b0;
            win_ok_o   <= 1'b0;
        end else begin
            win_done_o <= at_end && primed_q;
            if (at_end) begin
                snap_q   <= cur_bin;
                primed_q <= 1'b1;
                win_ok_o <= (delta >= LO_C) && (delta <= HI_C);
            end
        end
    end
endmodule

// File: rtl/fld_lock_fsm.sv
// Training / data recovery decision.
// It leaves training after LOCK_WINDOWS consecutive good windows and returns
// at once on a bad window or on loss of signal.
// Assumes: sig_q is already synchronized to clk.
module fld_lock_fsm #(
    parameter int LOCK_WINDOWS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_q,
    input  logic win_done,
    input  logic win_ok,
    output logic lol_o,
    output logic lol_status_o
);
    import fld_pkg::*;

    localparam int GW = $clog2(LOCK_WINDOWS + 1);

    mode_t         mode_q, mode_nxt;
    logic [GW-1:0] run_q,  run_nxt;

    // Next-state decision.
    always_comb begin
        mode_nxt = mode_q;
        run_nxt  = run_q;
        if (!sig_q) begin
            mode_nxt = MODE_TRAIN;
            run_nxt  = '0;
        end else if (win_done) begin
            if (!win_ok) begin
                mode_nxt = MODE_TRAIN;
                run_nxt  = '0;
            end else if (mode_q == MODE_TRAIN) begin
                if (run_q == GW'(LOCK_WINDOWS - 1)) begin
                    mode_nxt = MODE_TRACK;
                    run_nxt  = '0;
                end else begin
                    run_nxt = run_q + GW'(1);
                end
            end
        end
    end

    // State and host-visible status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= MODE_TRAIN;
            run_q        <= '0;
            lol_status_o <= 1'b1;
        end else begin
            mode_q       <= mode_nxt;
            run_q        <= run_nxt;
            lol_status_o <= (mode_nxt == MODE_TRAIN);
        end
    end

    assign lol_o = (mode_q == MODE_TRAIN);
endmodule

// File: rtl/fld_clk_mux.sv
// Glitch-free two-input clock multiplexer.
// Each enable is armed on its clock's rising edge only after the other enable
// has dropped, then applied on the falling edge.
// Assumes: both clocks keep running during a switch.
module fld_clk_mux (
    input  logic ref_clk,
    input  logic rst_ref_n,
    input  logic rec_clk,
    input  logic rst_rec_n,
    input  logic sel_rec,
    output logic clk_o,
    output logic ref_en_o,
    output logic rec_en_o
);
    logic ref_arm, rec_arm;

    // Arm the reference path once the recovered path is off.
    always_ff @(posedge ref_clk) begin
        if (!rst_ref_n) ref_arm <= 1'b0;
        else            ref_arm <= !sel_rec && !rec_en_o;
    end

    // Apply the reference enable while ref_clk is low.
    always_ff @(negedge ref_clk) begin
        if (!rst_ref_n) ref_en_o <= 1'b0;
        else            ref_en_o <= ref_arm;
    end

    // Arm the recovered path once the reference path is off.
    always_ff @(posedge rec_clk) begin
        if (!rst_rec_n) rec_arm <= 1'b0;
        else            rec_arm <= sel_rec && !ref_en_o;
    end

    // Apply the recovered enable while rec_clk is low.
    always_ff @(negedge rec_clk) begin
        if (!rst_rec_n) rec_en_o <= 1'b0;
        else            rec_en_o <= rec_arm;
    end

    assign clk_o = (ref_clk & ref_en_o) | (rec_clk & rec_en_o);
endmodule

// File: rtl/freq_lock_detector.sv
// Top: frequency lock detector with fallback of the receive clock.
// It measures rec_clk against ref_clk and selects the output clock.
// Assumes: rst_n is synchronous to ref_clk and rec_clk keeps running.
module freq_lock_detector #(
    parameter int WIN_LOG2      = 10,
    parameter int NOM_COUNT     = 1024,
    parameter int TOL_PER_MILLE = 5,
    parameter int LOCK_WINDOWS  = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic rec_clk,
    input  logic sig_present,
    output logic lol_o,
    output logic lol_status_o,
    output logic use_rec_o,
    output logic rx_clk_o
);
    localparam int TOL   = (NOM_COUNT * TOL_PER_MILLE) / 1000;
    localparam int LO    = NOM_COUNT - TOL;
    localparam int HI    = NOM_COUNT + TOL;
    localparam int CNT_W = $clog2(NOM_COUNT) + 3;

    logic [CNT_W-1:0] gray_rec, gray_ref;
    logic             rst_rec_n;
    logic             sig_q;
    logic             win_done, win_ok;
    logic             ref_en, rec_en;

    fld_gray_cnt #(.W(CNT_W)) u_cnt (
        .rec_clk     (rec_clk),
        .rst_n       (rst_n),
        .gray_o      (gray_rec),
        .rst_rec_n_o (rst_rec_n)
    );

    fld_sync2 #(.W(CNT_W)) u_sync_cnt (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (gray_rec),
        .q     (gray_ref)
    );

    fld_sync2 #(.W(1)) u_sync_sig (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (sig_present),
        .q     (sig_q)
    );

    fld_window #(
        .WIN_LOG2 (WIN_LOG2),
        .CNT_W    (CNT_W),
        .LO       (LO),
        .HI       (HI)
    ) u_win (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .gray_s     (gray_ref),
        .win_done_o (win_done),
        .win_ok_o   (win_ok)
    );

    fld_lock_fsm #(.LOCK_WINDOWS(LOCK_WINDOWS)) u_fsm (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .sig_q        (sig_q),
        .win_done     (win_done),
        .win_ok       (win_ok),
        .lol_o        (lol_o),
        .lol_status_o (lol_status_o)
    );

    assign use_rec_o = !lol_o;

    fld_clk_mux u_mux (
        .ref_clk   (ref_clk),
        .rst_ref_n (rst_n),
        .rec_clk   (rec_clk),
        .rst_rec_n (rst_rec_n),
        .sel_rec   (use_rec_o),
        .clk_o     (rx_clk_o),
        .ref_en_o  (ref_en),
        .rec_en_o  (rec_en)
    );
endmodule

// File: rtl/fld_checker.sv
// Checker: temporal properties of the lock detector, bound to the top.
module fld_checker (
    input logic ref_clk,
    input logic rst_n,
    input logic sig_q,
    input logic win_done,
    input logic win_ok,
    input logic lol_o,
    input logic ref_en,
    input logic rec_en
);
    AST_RESET_TRAINS: assert property (@(posedge ref_clk)
        $rose(rst_n) |-> lol_o);                                   // R1

    AST_NOSIG_TRAINS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !sig_q |=> lol_o);                                         // R2

    AST_BADWIN_TRAINS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (win_done && !win_ok) |=> lol_o);                          // R3

    AST_LOCK_ON_GOOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(lol_o) |-> $past(win_done && win_ok && sig_q));      // R4

    AST_EN_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(ref_en && rec_en));                                      // R8
endmodule

bind freq_lock_detector fld_checker u_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .sig_q    (sig_q),
    .win_done (win_done),
    .win_ok   (win_ok),
    .lol_o    (lol_o),
    .ref_en   (ref_en),
    .rec_en   (rec_en)
);

// File: tb/tb_freq_lock_detector.sv
`timescale 1ps/1ps
module tb_freq_lock_detector;
    localparam int REF_P   = 4000;           // 250 MHz
    localparam int WINLEN  = 1024;
    localparam int NOM     = 1024;
    localparam int TOL     = (NOM * 5) / 1000;
    localparam int LO      = NOM - TOL;
    localparam int HI      = NOM + TOL;
    localparam int WIN_PS  = WINLEN * REF_P;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic sig_present = 1'b0;
    logic lol_o, lol_status_o, use_rec_o, rx_clk_o;

    int rec_period = 4000;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit mon_on  = 1'b0;
    int min_w   = 1000000;
    int min_half = 1970;
    longint last_t = 0;

    freq_lock_detector dut (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .rec_clk      (rec_clk),
        .sig_present  (sig_present),
        .lol_o        (lol_o),
        .lol_status_o (lol_status_o),
        .use_rec_o    (use_rec_o),
        .rx_clk_o     (rx_clk_o)
    );

    always #(REF_P / 2) ref_clk = ~ref_clk;

    always begin
        #(rec_period / 2);
        rec_clk = ~rec_clk;
    end

    // Pulse-width monitor on the output clock (R8).
    always @(rx_clk_o) begin
        if (mon_on) begin
            if (int'($time - last_t) < min_w) min_w = int'($time - last_t);
        end
        last_t = $time;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic measure_rx(output int per);
        longint t0;
        @(posedge rx_clk_o);
        t0 = $time;
        repeat (8) @(posedge rx_clk_o);
        per = int'(($time - t0) / 8);
        @(negedge ref_clk);
    endtask

    // Predict lock: 1 = in band, 0 = out of band, -1 = ambiguous.
    function automatic int predict(input int p);
        int fl, cl;
        fl = WIN_PS / p;
        cl = (WIN_PS % p == 0) ? fl : fl + 1;
        if (fl >= LO && cl <= HI) return 1;
        if (cl < LO || fl > HI)   return 0;
        return -1;
    endfunction

    initial begin
        int per;
        int cls;
        wait_ref(10);
        rst_n = 1'b1;
        wait_ref(2);
        mon_on = 1'b1;
        // R1: reset state
        chk("R1 lol after reset", lol_o, 1);
        chk("R1 status after reset", lol_status_o, 1);
        chk("R1 select after reset", use_rec_o, 0);
        measure_rx(per);
        chk("R6 rx period in training", per, REF_P);

        // R5/R3/R7/R6: period sweep across the band
        for (int p = 3940; p <= 4078; p += 6) begin
            cls = predict(p);
            if (cls < 0) continue;
            sig_present = 1'b0;
            rec_period = p;
            wait_ref(10);
            sig_present = 1'b1;
            wait_ref(3 * WINLEN + 40);
            chk($sformatf("R5 lol at period %0d", p), lol_o, cls ? 0 : 1);
            chk("R9 status mirrors lol", lol_status_o, lol_o);
            chk("R9 select is complement", use_rec_o, !lol_o);
            measure_rx(per);
            if (cls == 1) chk($sformatf("R7 rx period %0d", p), per, p);
            else          chk($sformatf("R6 rx period at %0d", p), per, REF_P);
        end

        // Lock at nominal, then drop the signal (R2)
        rec_period = 4000;
        sig_present = 1'b1;
        wait_ref(3 * WINLEN + 40);
        chk("R4 locked at nominal", lol_o, 0);
        sig_present = 1'b0;
        wait_ref(4);
        chk("R2 lol within three edges of signal loss", lol_o, 1);
        wait_ref(2 * WINLEN);
        chk("R2 stays training while signal absent", lol_o, 1);
        measure_rx(per);
        chk("R6 rx period after signal loss", per, REF_P);

        // R4: one good window is not enough
        sig_present = 1'b1;
        wait_ref((WINLEN * 9) / 10);
        chk("R4 still training before second good window", lol_o, 1);
        wait_ref((WINLEN * 13) / 10 + 20);
        chk("R4 locked after two good windows", lol_o, 0);
        measure_rx(per);
        chk("R7 rx period after lock", per, 4000);

        // R3: a bad window unlocks a locked loop
        rec_period = 4400;
        wait_ref(2 * WINLEN + 40);
        chk("R3 slow clock drops lock", lol_o, 1);
        chk("R9 status after drop", lol_status_o, 1);
        measure_rx(per);
        chk("R6 rx period after drop", per, REF_P);

        // R8: no runt pulse seen through all switches
        chk("R8 min pulse width not below shortest half period",
            (min_w >= min_half) ? 1 : 0, 1);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(64'd200000 * REF_P);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule